// File: doc/BRIEF.md
# Request-Driven Macroblock Output Streamer

This block takes decimated video that already sits in a word-wide frame memory and hands it to a downstream encoder, one macroblock at a time, over a byte-wide data port qualified by a strobe. Once a whole field has been stored, upstream logic pulses `field_done`. The block then raises a frame-ready indication toward the encoder, but only while the control-register enable `frame_en` is set. The encoder answers with a macroblock request.

On each accepted request the block fetches 16-bit words through a simple request/valid read port. It is allowed one read slot per eight clocks, because line writes have priority on the memory. It collects the words in groups of four and sends each group as eight bytes, low byte first. The byte strobe runs at a quarter of the system clock and pulses only while a byte is valid.

Each macroblock needs its own request. The request line must fall and rise again before the next macroblock is sent. A cycle counter compares each transfer with a completion budget and sets a status flag when the transfer runs past it.

Top module: `mb_stream_out`

## Requirements
- R1: A `field_done` pulse sets an internal pending flag, and `frame_rdy` equals that flag ANDed with `frame_en`. Accepting a macroblock request clears the flag.
- R2: A transfer starts only when `mb_req` is high in a cycle after being low in the cycle before, and only while the block is idle. A rising edge of `mb_req` during a transfer is ignored.
- R3: Each accepted request produces exactly `MB_BYTES` strobe pulses on `out_stb`.
- R4: `out_stb` is a one-cycle pulse. Consecutive pulses within a transfer are a whole multiple of `STB_DIV` cycles apart. `out_byte` is valid in every cycle in which `out_stb` is high.
- R5: Words are read from consecutive addresses. The address continues from one macroblock to the next and wraps from `MEM_WORDS-1` to 0. Each word is sent as its bits [7:0] and then its bits [15:8].
- R6: `mem_rd_req` is a one-cycle pulse, at least `SLOT_CYCLES` cycles after the previous one. No new read is issued until `mem_rd_valid` has answered the previous read.
- R7: If the memory answers reads within `SLOT_CYCLES-1` cycles, the first strobe of a macroblock appears no more than `FIRST_MAX` cycles after the request is accepted.
- R8: After a macroblock completes, no further strobes appear until `mb_req` has gone low and then high again.
- R9: `budget_over` is set if a transfer is still running `BUDGET` cycles after its request was accepted. It stays set until the next request is accepted.
- R10: A synchronous active-low reset returns the block to idle with `out_stb`, `mem_rd_req`, `frame_rdy` and `budget_over` low. It also empties the word buffer and sets the read address back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_done | input | 1 | One-cycle pulse: a complete field is stored |
| frame_en | input | 1 | Control-register enable for the frame-ready output |
| frame_rdy | output | 1 | Frame-ready indication to the encoder |
| mb_req | input | 1 | Macroblock request from the encoder |
| mem_rd_req | output | 1 | One-cycle word read request |
| mem_rd_addr | output | ADDR_W | Word address of the read |
| mem_rd_valid | input | 1 | Read data valid, one cycle |
| mem_rd_data | input | WORD_W | Read data word |
| out_byte | output | 8 | Output byte |
| out_stb | output | 1 | Output byte strobe |
| budget_over | output | 1 | Transfer exceeded its cycle budget |

## Verification
The bench builds the block with 48-byte macroblocks (24 words, six groups of four), a 40-word memory and a budget of 400 cycles. Because 24 does not divide 40, successive macroblocks start at addresses 0, 24, 8, 32 and 16, so the address wrap is exercised in the middle of a transfer and every byte can be predicted from its address. The short macroblock also lets a run that holds back memory answers push one transfer well past its budget, while normal transfers stay inside it. This makes both states of the budget flag reachable, as well as a reset in the middle of a transfer followed by a restart from address 0.

// File: rtl/mbs_pkg.sv
// Shared types for the macroblock output streamer.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package mbs_pkg;

    // Transfer state of the streamer.
    typedef enum logic {
        MBS_IDLE = 1'b0,
        MBS_BUSY = 1'b1
    } mbs_state_e;

    // One output byte.
    typedef logic [7:0] mbs_byte_t;

endpackage

// File: rtl/mbs_req_ctl.sv
// Request control: detects a rising edge on the macroblock request and
// tracks whether a macroblock transfer is in progress.
// Assumes: mb_req is synchronous to clk; mb_done pulses once on the
// cycle the last byte of a macroblock is emitted.
module mbs_req_ctl
    import mbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mb_req,
    input  logic mb_done,
    output logic start,
    output logic busy
);

    logic       req_q;
    mbs_state_e state_q;

    // A transfer is accepted only on a fresh rising edge while idle.
    assign start = mb_req && !req_q && (state_q == MBS_IDLE);
    assign busy  = (state_q == MBS_BUSY);

    // Remember last cycle's request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= mb_req;
    end

    // Idle/busy state: enter on accepted request, leave on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                 state_q <= MBS_IDLE;
        else if (start)             state_q <= MBS_BUSY;
        else if (busy && mb_done)   state_q <= MBS_IDLE;
    end

    // R2: once busy, the block stays busy until the macroblock is done.
    a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mb_done) |=> busy);

endmodule

// File: rtl/mbs_fetch.sv
// Word fetcher: issues at most one memory read per slot window, keeps a
// single read outstanding, and collects GROUP_WORDS words into a group
// buffer that the serialiser takes whole.
// Assumes: the memory answers each read with exactly one mem_rd_valid
// pulse, at least one cycle after the request; stray valids are dropped.
module mbs_fetch #(
    parameter int WORD_W      = 16,
    parameter int GROUP_WORDS = 4,
    parameter int SLOT_CYCLES = 8,
    parameter int MB_WORDS    = 192,
    parameter int MEM_WORDS   = 262144,
    parameter int ADDR_W      = $clog2(MEM_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          busy,
    input  logic                          grp_take,
    input  logic                          mem_rd_valid,
    input  logic [WORD_W-1:0]             mem_rd_data,
    output logic                          mem_rd_req,
    output logic [ADDR_W-1:0]             mem_rd_addr,
    output logic                          grp_full,
    output logic [GROUP_WORDS*WORD_W-1:0] grp_data
);

    localparam int SLOT_W = $clog2(SLOT_CYCLES);
    localparam int GAP_W  = $clog2(SLOT_CYCLES + 1);
    localparam int ISS_W  = $clog2(MB_WORDS + 1);
    localparam int GW_W   = $clog2(GROUP_WORDS + 1);

    logic [SLOT_W-1:0] slot_q;
    logic [ISS_W-1:0]  issued_q;
    logic [GW_W-1:0]   wcnt_q;
    logic              outst_q;
    logic [ADDR_W-1:0] addr_q;
    logic              req_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [GAP_W-1:0]  gap_q;
    logic [WORD_W-1:0] buf_q [GROUP_WORDS];
    logic              issue;
    logic              accept;

    // Read only in the granted slot, one at a time, while the group has room.
    assign issue = busy && (slot_q == '0) && !outst_q
                && (issued_q < ISS_W'(MB_WORDS))
                && (wcnt_q < GW_W'(GROUP_WORDS));
    assign accept = mem_rd_valid && outst_q;

    assign mem_rd_req  = req_q;
    assign mem_rd_addr = raddr_q;
    assign grp_full    = (wcnt_q == GW_W'(GROUP_WORDS));

    // Free-running slot counter marking the one read slot in each window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 slot_q <= '0;
        else if (slot_q == SLOT_W'(SLOT_CYCLES-1))  slot_q <= '0;
        else                                        slot_q <= slot_q + SLOT_W'(1);
    end

    // Count words requested for the current macroblock.
    always_ff @(posedge clk) begin
        if (!rst_n)      issued_q <= '0;
        else if (start)  issued_q <= '0;
        else if (issue)  issued_q <= issued_q + ISS_W'(1);
    end

    // Track the single outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n)       outst_q <= 1'b0;
        else if (issue)   outst_q <= 1'b1;
        else if (accept)  outst_q <= 1'b0;
    end

    // Running word address, wrapping at the end of the frame memory.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (issue) begin
            if (addr_q == ADDR_W'(MEM_WORDS-1)) addr_q <= '0;
            else                                addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Registered read request pulse and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            raddr_q <= '0;
        end else begin
            req_q <= issue;
            if (issue) raddr_q <= addr_q;
        end
    end

    // Fill level of the group buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)        wcnt_q <= '0;
        else if (grp_take) wcnt_q <= '0;
        else if (accept)   wcnt_q <= wcnt_q + GW_W'(1);
    end

    // One storage slot per word of the group.
    for (genvar g = 0; g < GROUP_WORDS; g++) begin : g_word
        // Capture the returning word into its position in the group.
        always_ff @(posedge clk) begin
            if (!rst_n)                              buf_q[g] <= '0;
            else if (accept && wcnt_q == GW_W'(g))   buf_q[g] <= mem_rd_data;
        end
        assign grp_data[g*WORD_W +: WORD_W] = buf_q[g];
    end

    // Cycles since the last read request, saturating (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n)                             gap_q <= GAP_W'(SLOT_CYCLES);
        else if (req_q)                         gap_q <= '0;
        else if (gap_q != GAP_W'(SLOT_CYCLES))  gap_q <= gap_q + GAP_W'(1);
    end

    // R6: read requests are spaced by at least one slot window.
    a_r6_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (gap_q >= GAP_W'(SLOT_CYCLES-1)));

    // R5: a returning word always finds room in the group buffer.
    a_r5_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (wcnt_q < GW_W'(GROUP_WORDS)));

endmodule

// File: rtl/mbs_serial.sv
// Byte serialiser: takes a full group of words, shifts it out low byte
// first, one byte per STB_DIV cycles, and counts the bytes of the
// macroblock.
// Assumes: WORD_W is a multiple of 8; MB_BYTES is a multiple of the
// group size in bytes.
module mbs_serial #(
    parameter int WORD_W      = 16,
    parameter int GROUP_WORDS = 4,
    parameter int STB_DIV     = 4,
    parameter int MB_BYTES    = 384
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          busy,
    input  logic                          grp_full,
    input  logic [GROUP_WORDS*WORD_W-1:0] grp_data,
    output logic                          grp_take,
    output logic [7:0]                    out_byte,
    output logic                          out_stb,
    output logic                          mb_done
);

    localparam int GROUP_BYTES = GROUP_WORDS * WORD_W / 8;
    localparam int BL_W        = $clog2(GROUP_BYTES + 1);
    localparam int DIV_W       = $clog2(STB_DIV);
    localparam int SG_W        = $clog2(STB_DIV + 1);
    localparam int CNT_W       = $clog2(MB_BYTES + 1);

    logic [GROUP_WORDS*WORD_W-1:0] sh_q;
    logic [BL_W-1:0]               left_q;
    logic [DIV_W-1:0]              div_q;
    logic [CNT_W-1:0]              cnt_q;
    logic [7:0]                    byte_q;
    logic                          stb_q;
    logic [SG_W-1:0]               sgap_q;
    logic                          emit;

    // Load a new group only when the previous one is fully sent.
    assign grp_take = busy && grp_full && (left_q == '0);
    // Emit on the last phase of the divided clock when a byte is held.
    assign emit     = busy && (div_q == DIV_W'(STB_DIV-1)) && (left_q != '0);
    assign mb_done  = emit && (cnt_q == CNT_W'(MB_BYTES-1));

    assign out_byte = byte_q;
    assign out_stb  = stb_q;

    // Clock divider phase, running only during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)                  div_q <= '0;
        else if (div_q == DIV_W'(STB_DIV-1))  div_q <= '0;
        else                                  div_q <= div_q + DIV_W'(1);
    end

    // Shift register holding the group being sent.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (grp_take) sh_q <= grp_data;
        else if (emit)     sh_q <= sh_q >> 8;
    end

    // Bytes still to send from the current group.
    always_ff @(posedge clk) begin
        if (!rst_n)        left_q <= '0;
        else if (grp_take) left_q <= BL_W'(GROUP_BYTES);
        else if (emit)     left_q <= left_q - BL_W'(1);
    end

    // Bytes sent so far in this macroblock.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (start)  cnt_q <= '0;
        else if (emit)   cnt_q <= cnt_q + CNT_W'(1);
    end

    // Registered output byte and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            stb_q <= emit;
            if (emit) byte_q <= sh_q[7:0];
        end
    end

    // Cycles since the last strobe, saturating (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n)                          sgap_q <= SG_W'(STB_DIV);
        else if (stb_q)                      sgap_q <= '0;
        else if (sgap_q != SG_W'(STB_DIV))   sgap_q <= sgap_q + SG_W'(1);
    end

    // R4: strobes never come closer than the divided clock period.
    a_r4_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> (sgap_q >= SG_W'(STB_DIV-1)));

    // R3: the byte count never runs past one macroblock.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (cnt_q < CNT_W'(MB_BYTES)));

endmodule

// File: rtl/mb_stream_out.sv
// Top of the macroblock output streamer: frame-ready flag with enable,
// request control, rationed word fetch, byte serialiser, and a per-
// macroblock cycle budget monitor.
// Assumes: field_done is a one-cycle pulse; memory honours the
// request/valid handshake of mbs_fetch.
module mb_stream_out #(
    parameter int WORD_W      = 16,
    parameter int GROUP_WORDS = 4,
    parameter int SLOT_CYCLES = 8,
    parameter int STB_DIV     = 4,
    parameter int MB_BYTES    = 384,
    parameter int MEM_WORDS   = 262144,
    parameter int BUDGET      = 1870,
    parameter int FIRST_MAX   = 60,
    parameter int ADDR_W      = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_done,
    input  logic              frame_en,
    output logic              frame_rdy,
    input  logic              mb_req,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic [7:0]        out_byte,
    output logic              out_stb,
    output logic              budget_over
);

    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int MB_WORDS       = MB_BYTES / BYTES_PER_WORD;
    localparam int BUD_W          = $clog2(BUDGET + 1);
    localparam int LAT_W          = $clog2(FIRST_MAX + 2);

    logic                          start;
    logic                          busy;
    logic                          done;
    logic                          grp_take;
    logic                          grp_full;
    logic [GROUP_WORDS*WORD_W-1:0] grp_data;
    logic                          pend_q;
    logic [BUD_W-1:0]              bud_q;
    logic                          over_q;
    logic [LAT_W-1:0]              lat_q;
    logic                          seen_q;

    mbs_req_ctl u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .mb_req  (mb_req),
        .mb_done (done),
        .start   (start),
        .busy    (busy)
    );

    mbs_fetch #(
        .WORD_W      (WORD_W),
        .GROUP_WORDS (GROUP_WORDS),
        .SLOT_CYCLES (SLOT_CYCLES),
        .MB_WORDS    (MB_WORDS),
        .MEM_WORDS   (MEM_WORDS),
        .ADDR_W      (ADDR_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .busy         (busy),
        .grp_take     (grp_take),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .grp_full     (grp_full),
        .grp_data     (grp_data)
    );

    mbs_serial #(
        .WORD_W      (WORD_W),
        .GROUP_WORDS (GROUP_WORDS),
        .STB_DIV     (STB_DIV),
        .MB_BYTES    (MB_BYTES)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .grp_full (grp_full),
        .grp_data (grp_data),
        .grp_take (grp_take),
        .out_byte (out_byte),
        .out_stb  (out_stb),
        .mb_done  (done)
    );

    // Frame-ready output is the pending flag gated by the enable bit.
    assign frame_rdy   = pend_q && frame_en;
    assign budget_over = over_q;

    // Pending field flag: set by a stored field, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (field_done) pend_q <= 1'b1;
        else if (start)      pend_q <= 1'b0;
    end

    // Cycles elapsed in the current transfer, saturating at the budget.
    always_ff @(posedge clk) begin
        if (!rst_n)                                bud_q <= '0;
        else if (start)                            bud_q <= '0;
        else if (busy && bud_q != BUD_W'(BUDGET))  bud_q <= bud_q + BUD_W'(1);
    end

    // Sticky over-budget status, cleared when the next request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 over_q <= 1'b0;
        else if (start)                             over_q <= 1'b0;
        else if (busy && bud_q == BUD_W'(BUDGET))   over_q <= 1'b1;
    end

    // Cycles from acceptance to the first strobe (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            seen_q <= 1'b0;
        end else if (start) begin
            lat_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (out_stb) seen_q <= 1'b1;
            if (busy && !seen_q && lat_q != LAT_W'(FIRST_MAX+1))
                lat_q <= lat_q + LAT_W'(1);
        end
    end

    // R1: a stored field with the enable set shows up on frame_rdy.
    a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (field_done && frame_en) |=> (frame_rdy || !frame_en));

    // R4: a strobe only follows a cycle spent in a transfer.
    a_r4_stb_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(busy));

    // R7: the first strobe arrives within the latency limit.
    a_r7_first_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seen_q) |-> (lat_q <= LAT_W'(FIRST_MAX)));

    // R9: the budget flag can only rise during a transfer.
    a_r9_budget_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(budget_over) |-> $past(busy));

    // R10: the cycle after reset all outputs are quiet.
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_stb && !mem_rd_req && !budget_over && !frame_rdy));

endmodule

// File: tb/sim_mb_stream_out.sv
// Self-checking bench for mb_stream_out: 48-byte macroblocks, 40-word memory.
module sim_mb_stream_out;

    localparam int MBB   = 48;
    localparam int MBW   = MBB / 2;
    localparam int MEMW  = 40;
    localparam int FMAX  = 60;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        field_done;
    logic        frame_en;
    logic        frame_rdy;
    logic        mb_req;
    logic        mem_rd_req;
    logic [5:0]  mem_rd_addr;
    logic        mem_rd_valid;
    logic [15:0] mem_rd_data;
    logic [7:0]  out_byte;
    logic        out_stb;
    logic        budget_over;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    // memory model state
    bit pend = 0;
    int pend_addr = 0;
    int wait_left = 0;
    int served = 0;
    bit stall = 0;
    int rd_viol = 0;
    int last_req = 0;
    bit have_last = 0;

    // strobe monitor state
    logic [7:0] got [64];
    int ns = 0;
    int last_stb = 0;
    int first_cyc = 0;
    int stb_viol = 0;

    always #5 clk = ~clk;

    mb_stream_out #(
        .MB_BYTES  (MBB),
        .MEM_WORDS (MEMW),
        .BUDGET    (400),
        .FIRST_MAX (FMAX)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_done   (field_done),
        .frame_en     (frame_en),
        .frame_rdy    (frame_rdy),
        .mb_req       (mb_req),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .out_byte     (out_byte),
        .out_stb      (out_stb),
        .budget_over  (budget_over)
    );

    function automatic logic [15:0] memw(input int a);
        return 16'((a * 291) ^ 23235);
    endfunction

    function automatic logic [7:0] exp_byte(input int base, input int k);
        logic [15:0] w;
        w = memw((base + k / 2) % MEMW);
        return (k % 2 == 0) ? w[7:0] : w[15:8];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // cycle counter
    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // memory responder with R6 request monitoring
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        forever begin
            @(posedge clk);
            #1;
            mem_rd_valid = 1'b0;
            if (!rst_n) begin
                pend = 0;
                have_last = 0;
            end else if (mem_rd_req) begin
                if (pend) rd_viol++;
                if (have_last && (cyc - last_req) < 8) rd_viol++;
                last_req  = cyc;
                have_last = 1;
                pend      = 1;
                pend_addr = int'(mem_rd_addr);
                wait_left = (stall && served >= 4) ? 60 : 2;
            end else if (pend) begin
                wait_left--;
                if (wait_left == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = memw(pend_addr);
                    pend = 0;
                    served++;
                end
            end
        end
    end

    // strobe monitor with R4 spacing check data
    initial forever begin
        @(posedge clk);
        #1;
        if (out_stb) begin
            if (ns > 0 && (((cyc - last_stb) < 4) || ((cyc - last_stb) % 4 != 0)))
                stb_viol++;
            if (ns == 0) first_cyc = cyc;
            if (ns < 64) got[ns] = out_byte;
            ns++;
            last_stb = cyc;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_mb(input int base, input bit toggle, input bit stall_en, input bit exp_over);
        int req_cyc;
        int t;
        int mism;
        int bad;
        ns = 0;
        served = 0;
        stall = stall_en;
        @(posedge clk);
        #1;
        mb_req = 1'b1;
        req_cyc = cyc;
        if (toggle) begin
            repeat (60) @(posedge clk);
            #1 mb_req = 1'b0;
            @(posedge clk);
            #1 mb_req = 1'b1;
        end
        t = 0;
        while (ns < MBB && t < 4000) begin
            @(posedge clk);
            t++;
        end
        #2;
        chk(ns == MBB, "R3 byte count per macroblock", ns, MBB);
        mism = 0;
        bad = 0;
        for (int k = 0; k < MBB; k++) begin
            if (got[k] !== exp_byte(base, k)) begin
                if (mism == 0) bad = k;
                mism++;
            end
        end
        chk(mism == 0, "R5 byte order and address sequence", int'(got[bad]), int'(exp_byte(base, bad)));
        chk((first_cyc - req_cyc) <= FMAX, "R7 first strobe latency", first_cyc - req_cyc, FMAX);
        chk(stb_viol == 0, "R4 strobe spacing", stb_viol, 0);
        chk(frame_rdy == 1'b0, "R1 flag cleared by accepted request", int'(frame_rdy), 0);
        chk(budget_over == exp_over, "R9 budget flag", int'(budget_over), int'(exp_over));
        // request stays high: nothing more may come out
        repeat (120) @(posedge clk);
        #2;
        chk(ns == MBB, toggle ? "R2 mid-transfer edge ignored" : "R8 no restart while request held",
            ns, MBB);
        mb_req = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int base;
        rst_n      = 1'b0;
        field_done = 1'b0;
        frame_en   = 1'b0;
        mb_req     = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        chk(out_stb == 1'b0, "R10 reset strobe low", int'(out_stb), 0);
        chk(mem_rd_req == 1'b0, "R10 reset read request low", int'(mem_rd_req), 0);
        chk(frame_rdy == 1'b0, "R10 reset frame ready low", int'(frame_rdy), 0);
        chk(budget_over == 1'b0, "R10 reset budget flag low", int'(budget_over), 0);
        rst_n = 1'b1;

        // R1: masked then enabled
        @(posedge clk);
        #1 field_done = 1'b1;
        @(posedge clk);
        #1 field_done = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(frame_rdy == 1'b0, "R1 masked by enable", int'(frame_rdy), 0);
        frame_en = 1'b1;
        #1;
        chk(frame_rdy == 1'b1, "R1 shown when enabled", int'(frame_rdy), 1);

        // normal macroblocks walking across the address wrap
        base = 0;
        run_mb(base, 0, 0, 0);
        base = (base + MBW) % MEMW;
        @(posedge clk);
        #1 field_done = 1'b1;
        @(posedge clk);
        #1 field_done = 1'b0;
        #1;
        chk(frame_rdy == 1'b1, "R1 set again by new field", int'(frame_rdy), 1);
        run_mb(base, 0, 0, 0);
        base = (base + MBW) % MEMW;
        run_mb(base, 1, 0, 0);
        base = (base + MBW) % MEMW;
        // R9: slow memory pushes past the budget
        run_mb(base, 0, 1, 1);
        base = (base + MBW) % MEMW;
        run_mb(base, 0, 0, 0);

        // R10: reset in the middle of a transfer
        ns = 0;
        served = 0;
        stall = 0;
        @(posedge clk);
        #1 mb_req = 1'b1;
        repeat (100) @(posedge clk);
        #1 field_done = 1'b1;
        @(posedge clk);
        #1 field_done = 1'b0;
        #1;
        chk(frame_rdy == 1'b1, "R1 flag during transfer", int'(frame_rdy), 1);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk(out_stb == 1'b0, "R10 mid-transfer reset strobe", int'(out_stb), 0);
        chk(mem_rd_req == 1'b0, "R10 mid-transfer reset read", int'(mem_rd_req), 0);
        mb_req = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk(frame_rdy == 1'b0, "R10 frame ready cleared by reset", int'(frame_rdy), 0);
        repeat (20) @(posedge clk);
        #1;
        run_mb(0, 0, 0, 0);

        chk(rd_viol == 0, "R6 read spacing and single outstanding", rd_viol, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule